// File: doc/BRIEF.md
# Multiplexed BCD Port Load Sequencer

This block owns a shared four-bit BCD port that serves two purposes on a scanned four-digit display counter. In normal operation it drives out the held display digits one at a time, following the same most-significant-first scan that strobes the digit lines. When a load is requested, it turns the port around and reads one thumbwheel digit per scan phase, handing each digit to the counter, to the preset register, or to both, through per-digit strobes. The arithmetic, the comparison and the segment decoding sit outside this block.

Each of the two load controls is a three-level input (driven low, left open, driven high), delivered as a two-bit code and synchronized inside the block. A rising request to the high level starts a full four-digit load cycle. The cycle restarts from the top digit and runs on an internal tick, not on the external scan tick. At the end of each cycle the requests are checked again, and loading repeats for as long as a request is present. A low level on either control turns the port off. A low level on the register control also blanks the display and freezes the scan. The captured digits are strobes with no flow control, because the counter and register always accept a digit in the cycle it is presented. No valid/ready handshake is used, and there is no back-pressure.

Top module: `bcd_port_seq`

## Requirements
- R1: Each control code is decoded as 00 = low, 01 = open, 10 = high and 11 = open. The codes pass through SYNC_STAGES flops before use. A code of 11 on either input behaves exactly like open.
- R2: With both controls open and no load running, `port_oe` is 1 and `port_dout` carries the held digit of the current phase. `latch_digits[4k+3:4k]` is digit k, and digit 3 is the most significant. The phase starts at 3 out of reset and steps 3→2→1→0→3 on each `scan_tick` pulse. `digit_sel` is one-hot, with bit k meaning phase k.
- R3: A low level on either control forces `port_oe` to 0 and `port_dout` to 0. A low level on the register control, outside a load, also raises `display_off`, clears `digit_sel` and holds the phase still.
- R4: When either control rises to high, a load cycle begins. The phase is forced to 3, `flags_invalid` is 1 for the whole cycle, and `port_oe` is 0. Each digit lasts LOAD_DIV clock cycles, timed internally, and `scan_tick` is ignored.
- R5: On the last clock of each digit's on-period, `bcd_in` is captured. In the next cycle the captured value appears on `ld_digit` with a one-cycle strobe on bit k of the target strobe vectors. The digits are visited in the order 3, 2, 1, 0.
- R6: A counter request drives `cnt_ld_stb` and holds `count_inhibit` high during the cycle. A register request drives only `reg_ld_stb`. When both are requested, both strobe vectors pulse together with the same digit.
- R7: After digit 0, the requests are sampled again. A control that is still high, or a request edge seen during the cycle, starts another cycle at digit 3. Otherwise normal operation resumes at phase 3.
- R8: A request edge that arrives in the middle of a cycle is remembered, even if the control has fallen before the cycle ends. It produces one more cycle for that target.
- R9: With COMMON_CATHODE = 1, `bcd_in` is low-true, so `ld_digit` is the bitwise inverse of the sampled nibble. `port_dout` is high-true for both settings.
- R10: During and after reset, no load is running, the phase is 3, all strobes are 0, `ld_digit` is 0, and with open controls the port drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lc_code | input | 2 | Three-level counter-load control code |
| lr_code | input | 2 | Three-level register-load control code |
| scan_tick | input | 1 | External one-cycle scan advance pulse |
| bcd_in | input | 4 | Thumbwheel nibble read from the port |
| latch_digits | input | 4*NUM_DIGITS | Held display digits, digit 0 in the low nibble |
| port_oe | output | 1 | Port drive enable |
| port_dout | output | 4 | Nibble driven onto the port |
| digit_sel | output | NUM_DIGITS | One-hot active digit strobe |
| ld_digit | output | 4 | Captured digit, high-true |
| cnt_ld_stb | output | NUM_DIGITS | Per-digit counter load strobe |
| reg_ld_stb | output | NUM_DIGITS | Per-digit register load strobe |
| count_inhibit | output | 1 | Counting must pause |
| flags_invalid | output | 1 | Zero/equal flags not valid |
| display_off | output | 1 | Display blanked |

## Verification
The assertions check the following on every cycle:
- at most one digit strobe fires at a time;
- strobes fire only after a cycle in which a load was running;
- every load begins at the top digit;
- the load phase only steps downward;
- the port is silent while loading;
- the scan stays frozen while the register control is low;
- count inhibit never appears outside a load.

Other properties can only be shown by the bench scenarios, which compare against the reference model: the digit order and the exact timing of the captures, which targets receive each digit, whether a load repeats or ends after the re-sample point, the remembered mid-cycle request, and the inverted input sense.

// File: rtl/bcd_port_pkg.sv
package bcd_port_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_OPEN = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_t;

  // Three-level decode; the unused code falls back to the idle level
  function automatic lvl_t decode_lvl(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LOW;
      2'b10:   return LVL_HIGH;
      default: return LVL_OPEN;
    endcase
  endfunction

endpackage

// File: rtl/bcd_lvl_sync.sv
module bcd_lvl_sync
  import bcd_port_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code_in,
  output logic       is_low,
  output logic       is_high,
  output logic       rise_high
);

  logic [1:0] pipe [STAGES];
  logic       prev_high;
  lvl_t       lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= 2'b01;
      prev_high <= 1'b0;
    end else begin
      pipe[0] <= code_in;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev_high <= is_high;
    end
  end

  always_comb begin
    lvl       = decode_lvl(pipe[STAGES-1]);
    is_low    = (lvl == LVL_LOW);
    is_high   = (lvl == LVL_HIGH);
    rise_high = is_high && !prev_high;
  end

endmodule

// File: rtl/bcd_load_tick.sv
module bcd_load_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/bcd_load_fsm.sv
module bcd_load_fsm #(
  parameter int N  = 4,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lc_high,
  input  logic          lr_high,
  input  logic          lc_rise,
  input  logic          lr_rise,
  input  logic          lr_low,
  input  logic          scan_tick,
  input  logic          tick,
  input  logic [3:0]    din,
  output logic          load_active,
  output logic          load_cnt,
  output logic [PW-1:0] phase,
  output logic [N-1:0]  stb_c,
  output logic [N-1:0]  stb_r,
  output logic [3:0]    ld_dig
);

  localparam logic [PW-1:0] TOP = PW'(N - 1);

  logic load_q, ldc_q, ldr_q, pend_c, pend_r;
  logic any_req, start, last, again, capture;
  logic nxt_ldc, nxt_ldr;
  logic [PW-1:0] phase_dn;

  always_comb begin
    any_req  = lc_rise || lr_rise || pend_c || pend_r;
    start    = !load_q && any_req;
    last     = load_q && tick && (phase == '0);
    again    = last && (lc_high || lr_high || any_req);
    capture  = start || again;
    nxt_ldc  = (again && lc_high) || lc_rise || pend_c;
    nxt_ldr  = (again && lr_high) || lr_rise || pend_r;
    phase_dn = (phase == '0) ? TOP : phase - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      ldc_q  <= 1'b0;
      ldr_q  <= 1'b0;
      pend_c <= 1'b0;
      pend_r <= 1'b0;
      phase  <= TOP;
      stb_c  <= '0;
      stb_r  <= '0;
      ld_dig <= '0;
    end else begin
      pend_c <= capture ? 1'b0 : (pend_c || lc_rise);
      pend_r <= capture ? 1'b0 : (pend_r || lr_rise);
      stb_c  <= '0;
      stb_r  <= '0;
      if (start) begin
        load_q <= 1'b1;
        phase  <= TOP;
        ldc_q  <= nxt_ldc;
        ldr_q  <= nxt_ldr;
      end else if (load_q) begin
        if (tick) begin
          ld_dig       <= din;
          stb_c[phase] <= ldc_q;
          stb_r[phase] <= ldr_q;
          phase        <= phase_dn;
          if (last) begin
            if (again) begin
              ldc_q <= nxt_ldc;
              ldr_q <= nxt_ldr;
            end else begin
              load_q <= 1'b0;
            end
          end
        end
      end else if (scan_tick && !lr_low) begin
        phase <= phase_dn;
      end
    end
  end

  assign load_active = load_q;
  assign load_cnt    = load_q && ldc_q;

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_c | stb_r)); // R5
  AST_STB_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|stb_c) || (|stb_r)) |-> $past(load_q)); // R5
  AST_START_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_q) |-> (phase == TOP)); // R4
  AST_LOAD_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && $past(load_q) && !$stable(phase)) |->
      (phase == (($past(phase) == '0) ? TOP : $past(phase) - 1'b1))); // R5
  AST_SCAN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_q && $past(!load_q) && $past(lr_low)) |-> $stable(phase)); // R3

endmodule

// File: rtl/bcd_port_seq.sv
module bcd_port_seq #(
  parameter int NUM_DIGITS     = 4,
  parameter int SYNC_STAGES    = 2,
  parameter int LOAD_DIV       = 4,
  parameter bit COMMON_CATHODE = 1'b0,
  localparam int PW = $clog2(NUM_DIGITS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              lc_code,
  input  logic [1:0]              lr_code,
  input  logic                    scan_tick,
  input  logic [3:0]              bcd_in,
  input  logic [4*NUM_DIGITS-1:0] latch_digits,
  output logic                    port_oe,
  output logic [3:0]              port_dout,
  output logic [NUM_DIGITS-1:0]   digit_sel,
  output logic [3:0]              ld_digit,
  output logic [NUM_DIGITS-1:0]   cnt_ld_stb,
  output logic [NUM_DIGITS-1:0]   reg_ld_stb,
  output logic                    count_inhibit,
  output logic                    flags_invalid,
  output logic                    display_off
);

  logic lc_low, lc_high, lc_rise, lr_low, lr_high, lr_rise;
  logic tick, load_active, load_cnt;
  logic [PW-1:0] phase;
  logic [3:0] din_true;
  logic [3:0] digs [NUM_DIGITS];

  bcd_lvl_sync #(.STAGES(SYNC_STAGES)) u_lc_sync (
    .clk(clk), .rst_n(rst_n), .code_in(lc_code),
    .is_low(lc_low), .is_high(lc_high), .rise_high(lc_rise));

  bcd_lvl_sync #(.STAGES(SYNC_STAGES)) u_lr_sync (
    .clk(clk), .rst_n(rst_n), .code_in(lr_code),
    .is_low(lr_low), .is_high(lr_high), .rise_high(lr_rise));

  bcd_load_tick #(.DIV(LOAD_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(load_active), .tick(tick));

  generate
    if (COMMON_CATHODE) begin : g_low_true
      assign din_true = ~bcd_in;
    end else begin : g_high_true
      assign din_true = bcd_in;
    end
  endgenerate

  bcd_load_fsm #(.N(NUM_DIGITS)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .lc_high(lc_high), .lr_high(lr_high),
    .lc_rise(lc_rise), .lr_rise(lr_rise), .lr_low(lr_low),
    .scan_tick(scan_tick), .tick(tick), .din(din_true),
    .load_active(load_active), .load_cnt(load_cnt), .phase(phase),
    .stb_c(cnt_ld_stb), .stb_r(reg_ld_stb), .ld_dig(ld_digit));

  genvar g;
  generate
    for (g = 0; g < NUM_DIGITS; g++) begin : g_dig
      assign digs[g]      = latch_digits[4*g +: 4];
      assign digit_sel[g] = !display_off && (phase == PW'(g));
    end
  endgenerate

  assign display_off   = lr_low && !load_active;
  assign port_oe       = !load_active && !lc_low && !lr_low;
  assign port_dout     = port_oe ? digs[phase] : 4'h0;
  assign count_inhibit = load_cnt;
  assign flags_invalid = load_active;

  AST_PORT_QUIET_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flags_invalid |-> (!port_oe && port_dout == 4'h0)); // R4
  AST_INHIBIT_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    count_inhibit |-> flags_invalid); // R6
  AST_DARK_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    display_off |-> (digit_sel == '0)); // R3

endmodule

// File: tb/bcd_port_seq_bench.sv
module bcd_port_seq_bench;

  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int DIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] lc_code = 2'b01, lr_code = 2'b01;
  logic scan_tick = 1'b0;
  logic [3:0] bcd_in = 4'h0;
  logic [15:0] latch_digits = 16'h0000;

  logic port_oe, count_inhibit, flags_invalid, display_off;
  logic [3:0] port_dout, ld_digit, ld_digit_cc;
  logic [N-1:0] digit_sel, cnt_ld_stb, reg_ld_stb;
  logic cc_oe, cc_inh, cc_inv, cc_off;
  logic [3:0] cc_dout;
  logic [N-1:0] cc_sel, cc_cs, cc_rs;

  int compared = 0, mismatched = 0, cyc = 0;
  string scen = "R10";
  bit running = 1'b0, done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bcd_port_seq #(.NUM_DIGITS(N), .LOAD_DIV(DIV), .COMMON_CATHODE(1'b0)) u_bcd_port_seq (
    .clk(clk), .rst_n(rst_n), .lc_code(lc_code), .lr_code(lr_code),
    .scan_tick(scan_tick), .bcd_in(bcd_in), .latch_digits(latch_digits),
    .port_oe(port_oe), .port_dout(port_dout), .digit_sel(digit_sel),
    .ld_digit(ld_digit), .cnt_ld_stb(cnt_ld_stb), .reg_ld_stb(reg_ld_stb),
    .count_inhibit(count_inhibit), .flags_invalid(flags_invalid),
    .display_off(display_off));

  bcd_port_seq #(.NUM_DIGITS(N), .LOAD_DIV(DIV), .COMMON_CATHODE(1'b1)) u_cc (
    .clk(clk), .rst_n(rst_n), .lc_code(lc_code), .lr_code(lr_code),
    .scan_tick(scan_tick), .bcd_in(bcd_in), .latch_digits(latch_digits),
    .port_oe(cc_oe), .port_dout(cc_dout), .digit_sel(cc_sel),
    .ld_digit(ld_digit_cc), .cnt_ld_stb(cc_cs), .reg_ld_stb(cc_rs),
    .count_inhibit(cc_inh), .flags_invalid(cc_inv), .display_off(cc_off));

  // Reference model state
  int m_s1c = 1, m_s2c = 1, m_s1r = 1, m_s2r = 1;
  bit m_hc = 0, m_hr = 0, m_load = 0, m_ldc = 0, m_ldr = 0, m_pc = 0, m_pr = 0;
  int m_ph = N - 1, m_dc = 0;
  logic [N-1:0] m_cs = '0, m_rs = '0;
  logic [3:0] m_dig = 4'h0, m_dig_cc = 4'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1c = 1; m_s2c = 1; m_s1r = 1; m_s2r = 1;
      m_hc = 0; m_hr = 0; m_load = 0; m_ldc = 0; m_ldr = 0; m_pc = 0; m_pr = 0;
      m_ph = N - 1; m_dc = 0; m_cs = '0; m_rs = '0; m_dig = 0; m_dig_cc = 0;
    end else begin
      bit lch, lrh, lrl, ec, er, cap, req;
      int code_c, code_r;
      code_c = (m_s2c == 3) ? 1 : m_s2c;
      code_r = (m_s2r == 3) ? 1 : m_s2r;
      lch = (code_c == 2); lrh = (code_r == 2); lrl = (code_r == 0);
      ec = lch && !m_hc; er = lrh && !m_hr;
      req = ec || er || m_pc || m_pr;
      cap = 0;
      m_cs = '0; m_rs = '0;
      if (!m_load) begin
        if (req) begin
          cap = 1; m_load = 1; m_ph = N - 1; m_dc = 0;
          m_ldc = ec || m_pc; m_ldr = er || m_pr;
        end else if (scan_tick && !lrl) begin
          m_ph = (m_ph + N - 1) % N;
        end
      end else begin
        if (m_dc == DIV - 1) begin
          m_dc = 0;
          m_dig = bcd_in; m_dig_cc = ~bcd_in;
          m_cs[m_ph] = m_ldc; m_rs[m_ph] = m_ldr;
          if (m_ph == 0) begin
            if (lch || lrh || req) begin
              cap = 1;
              m_ldc = lch || ec || m_pc; m_ldr = lrh || er || m_pr;
            end else m_load = 0;
          end
          m_ph = (m_ph + N - 1) % N;
        end else m_dc = m_dc + 1;
      end
      m_pc = cap ? 0 : (m_pc || ec);
      m_pr = cap ? 0 : (m_pr || er);
      m_hc = lch; m_hr = lrh;
      m_s2c = m_s1c; m_s1c = int'(lc_code);
      m_s2r = m_s1r; m_s1r = int'(lr_code);
    end
  end

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL [%s] %s %s actual=%0h expected=%0h t=%0t", scen, req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      bit lcl, lrl, oe, off;
      logic [N-1:0] sel;
      lcl = (m_s2c == 0); lrl = (m_s2r == 0);
      oe  = !m_load && !lcl && !lrl;
      off = lrl && !m_load;
      sel = off ? '0 : (N'(1) << m_ph);
      chk("R3", "port_oe", 32'(port_oe), 32'(oe));
      chk("R2", "port_dout", 32'(port_dout), oe ? 32'(latch_digits[4*m_ph +: 4]) : 0);
      chk("R2", "digit_sel", 32'(digit_sel), 32'(sel));
      chk("R3", "display_off", 32'(display_off), 32'(off));
      chk("R4", "flags_invalid", 32'(flags_invalid), 32'(m_load));
      chk("R6", "count_inhibit", 32'(count_inhibit), 32'(m_load && m_ldc));
      chk("R5", "cnt_ld_stb", 32'(cnt_ld_stb), 32'(m_cs));
      chk("R6", "reg_ld_stb", 32'(reg_ld_stb), 32'(m_rs));
      chk("R5", "ld_digit", 32'(ld_digit), 32'(m_dig));
      chk("R9", "ld_digit_cc", 32'(ld_digit_cc), 32'(m_dig_cc));
      chk("R9", "port_dout_cc", 32'(cc_dout), 32'(port_dout));
    end
  end

  // Free-running stimulus: scan pulses every 5 cycles, changing thumbwheel data
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    scan_tick = (cyc % 5 == 0);
    bcd_in    = 4'((cyc * 7 + 3) % 10);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_codes(logic [1:0] c, logic [1:0] r);
    @(posedge clk); #1;
    lc_code = c; lr_code = r;
  endtask

  always @(posedge clk) begin
    if (cyc > 4000 && !done) begin
      mismatched++;
      $display("FAIL [watchdog] run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    latch_digits = 16'h9581;
    running = 1'b1;
    scen = "R10";
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    scen = "R2"; wait_cyc(30);
    latch_digits = 16'h2704; wait_cyc(20);
    scen = "R3"; set_codes(2'b01, 2'b00); wait_cyc(14);
    set_codes(2'b01, 2'b01); wait_cyc(5);
    set_codes(2'b00, 2'b01); wait_cyc(10);
    set_codes(2'b01, 2'b01); wait_cyc(5);
    scen = "R1"; set_codes(2'b11, 2'b11); wait_cyc(12);
    set_codes(2'b01, 2'b01); wait_cyc(4);
    scen = "R4"; set_codes(2'b10, 2'b01); wait_cyc(2);
    set_codes(2'b01, 2'b01); wait_cyc(30);
    scen = "R6"; set_codes(2'b01, 2'b10); wait_cyc(40);
    set_codes(2'b01, 2'b01); wait_cyc(30);
    set_codes(2'b10, 2'b10); wait_cyc(3);
    set_codes(2'b01, 2'b01); wait_cyc(30);
    scen = "R8"; set_codes(2'b10, 2'b01); wait_cyc(3);
    set_codes(2'b01, 2'b01); wait_cyc(6);
    set_codes(2'b01, 2'b10); wait_cyc(2);
    set_codes(2'b01, 2'b01); wait_cyc(50);
    scen = "R7"; set_codes(2'b10, 2'b01); wait_cyc(22);
    set_codes(2'b01, 2'b01); wait_cyc(40);
    scen = "R3"; set_codes(2'b10, 2'b00); wait_cyc(30);
    set_codes(2'b01, 2'b01); wait_cyc(30);
    done = 1'b1;
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule